// File: doc/BRIEF.md
# Address-Masked GPIO Port

This block is an eight-pin general-purpose I/O port that sits on a simple byte-wide memory-mapped register bus. Each pin has a direction bit and an output data bit. A pin whose direction bit is 1 drives its stored output value. A pin whose direction bit is 0 floats, and its pad level can be read back through a two-flop synchronizer.

The data register is reached through a 1 KiB address window rather than a single address. Address bits [9:2] of any access in that window act as a per-pin mask. Pin n is selected by address bit n+2. A store changes only the selected pins, so software can set or clear any subset of pins in one bus write, with no read-modify-write and no lock. A load returns zero in every unselected bit position.

Bus writes take effect on the clock edge that samples the strobe. Read data is registered and appears on the cycle after the strobe. The pad drivers are presented as two separate vectors, an output value and an output enable, so that the pad ring can instantiate its own tristate cells.

Top module: `gpio_masked_port`

## Requirements
- R1: A synchronous active-high reset clears the direction and output data registers and the read data, so pad_oe, pad_out and bus_rdata are all 0 after reset.
- R2: A write to byte address 0x400 (address bits [1:0] ignored) loads the direction register from bus_wdata, and pad_oe shows the new value on the next cycle. Bit value 1 means output and 0 means input.
- R3: A read at address 0x400 returns the direction register on bus_rdata in the cycle after the read strobe.
- R4: A write to an address in 0x000–0x3FF updates output data bit n only when address bit n+2 is 1. All other bits keep their values, and an address with all mask bits 0 changes nothing.
- R5: A data write has no effect on the stored value of a pin that is currently an input. A later switch of that pin to output drives the value the pin held before that write.
- R6: A data read returns 0 in every bit whose address mask bit (address bit n+2) is 0.
- R7: For a selected output pin, a data read returns the driven output value, whatever level is on the pad.
- R8: For a selected input pin, a data read returns the pad level through two synchronizing flops. A read strobe sampled at the first or second rising edge after a pad change returns the old level, and a read strobe sampled at the third rising edge returns the new level.
- R9: bus_rdata is 0 in every cycle that follows a cycle with no read strobe.
- R10: Accesses to addresses of 0x404 and above change no register and read back as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read, qualified by bus_sel |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data, valid the cycle after a read strobe |
| pad_in | input | 8 | Asynchronous pad levels |
| pad_out | output | 8 | Output value for each pad |
| pad_oe | output | 8 | Output enable for each pad, 1 = driven |

## Verification
The bench targets the following faults:
- Mask bit ordering is off by one. A correct masked store touches only the named pins, so a design that decodes the mask from the wrong address bits alters the wrong pins.
- A store reaches an input pin. The hidden output value is exposed later by turning those pins into outputs, and a design that wrote the input bits drives 1s that should be 0s.
- The synchronizer has the wrong depth. Three back-to-back reads straddle a pad change, and a design with one flop too few or too many returns the new level a cycle early or late.
- The read mux picks the wrong source for output pins. Reads with the pad opposite to the driven value catch this.
- Decoding is incomplete. Stores and loads outside both windows catch a design that aliases them onto the direction or data register.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_DATA = 2'd1,
    ACC_DIR  = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_pkg::*;
#(
  parameter int NUM_PINS   = 8,
  parameter int ADDR_W     = 12,
  parameter int DIR_OFFSET = 'h400
) (
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  output acc_kind_e           kind,
  output logic [NUM_PINS-1:0] pin_mask,
  output logic                data_we,
  output logic                dir_we,
  output logic                rd_en
);
  localparam int MASK_LSB = 2;
  localparam int WIN_MSB  = MASK_LSB + NUM_PINS;
  localparam logic [ADDR_W-1:0] DIR_WORD = ADDR_W'(DIR_OFFSET >> MASK_LSB);

  logic in_data_win;
  logic in_dir_word;

  always_comb begin
    in_data_win = ((bus_addr >> WIN_MSB) == '0);
    in_dir_word = ((bus_addr >> MASK_LSB) == DIR_WORD);
    if (in_data_win)      kind = ACC_DATA;
    else if (in_dir_word) kind = ACC_DIR;
    else                  kind = ACC_NONE;
    pin_mask = bus_addr[MASK_LSB +: NUM_PINS];
    data_we  = bus_sel && bus_wr && (kind == ACC_DATA);
    dir_we   = bus_sel && bus_wr && (kind == ACC_DIR);
    rd_en    = bus_sel && !bus_wr;
  end

  // R10: a write never targets both registers at once
  always_comb begin
    a_r10_single_target: assert (!(data_we && dir_we));
  end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= async_in;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs #(
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                data_we,
  input  logic                dir_we,
  input  logic [NUM_PINS-1:0] pin_mask,
  input  logic [NUM_PINS-1:0] wdata,
  output logic [NUM_PINS-1:0] dir_q,
  output logic [NUM_PINS-1:0] data_q
);
  always_ff @(posedge clk) begin
    if (rst) dir_q <= '0;
    else if (dir_we) dir_q <= wdata;
  end

  generate
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      always_ff @(posedge clk) begin
        if (rst) data_q[i] <= 1'b0;
        else if (data_we && pin_mask[i] && dir_q[i]) data_q[i] <= wdata[i];
      end
    end
  endgenerate

  // R2: direction register takes the written byte
  a_r2_dir_load: assert property (@(posedge clk) disable iff (rst)
    dir_we |=> (dir_q == $past(wdata)));
  // R4: unselected pins keep their values across a data write
  a_r4_unmasked_hold: assert property (@(posedge clk) disable iff (rst)
    data_we |=> (((data_q ^ $past(data_q)) & ~$past(pin_mask)) == '0));
  // R5: input pins keep their stored output value across a data write
  a_r5_input_hold: assert property (@(posedge clk) disable iff (rst)
    data_we |=> (((data_q ^ $past(data_q)) & ~$past(dir_q)) == '0));
  // R4: with no data write, the output data register is stable
  a_r4_idle_stable: assert property (@(posedge clk) disable iff (rst)
    !data_we |=> $stable(data_q));
endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
  import gpio_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rd_en,
  input  acc_kind_e           kind,
  input  logic [NUM_PINS-1:0] pin_mask,
  input  logic [NUM_PINS-1:0] dir_q,
  input  logic [NUM_PINS-1:0] data_q,
  input  logic [NUM_PINS-1:0] pin_sync,
  output logic [NUM_PINS-1:0] rdata_q
);
  logic [NUM_PINS-1:0] pin_view;
  logic [NUM_PINS-1:0] rd_next;

  always_comb begin
    pin_view = (dir_q & data_q) | (~dir_q & pin_sync);
    unique case (kind)
      ACC_DATA: rd_next = pin_view & pin_mask;
      ACC_DIR:  rd_next = dir_q;
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !rd_en) rdata_q <= '0;
    else rdata_q <= rd_next;
  end

  // R9: no strobe, no data
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rdata_q == '0));
  // R6: unselected bits read as zero
  a_r6_masked_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && kind == ACC_DATA) |=> ((rdata_q & ~$past(pin_mask)) == '0));
  // R3: direction read-back
  a_r3_dir_readback: assert property (@(posedge clk) disable iff (rst)
    (rd_en && kind == ACC_DIR) |=> (rdata_q == $past(dir_q)));
  // R10: out-of-window reads are zero
  a_r10_hole_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && kind == ACC_NONE) |=> (rdata_q == '0));
endmodule

// File: rtl/gpio_masked_port.sv
module gpio_masked_port
  import gpio_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int ADDR_W      = 12,
  parameter int DIR_OFFSET  = 'h400,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [NUM_PINS-1:0] bus_wdata,
  output logic [NUM_PINS-1:0] bus_rdata,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe
);
  acc_kind_e           kind;
  logic [NUM_PINS-1:0] pin_mask;
  logic                data_we;
  logic                dir_we;
  logic                rd_en;
  logic [NUM_PINS-1:0] dir_q;
  logic [NUM_PINS-1:0] data_q;
  logic [NUM_PINS-1:0] pin_sync;

  gpio_addr_decode #(
    .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DIR_OFFSET(DIR_OFFSET)
  ) u_decode (
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .kind(kind), .pin_mask(pin_mask), .data_we(data_we),
    .dir_we(dir_we), .rd_en(rd_en)
  );

  gpio_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk(clk), .rst(rst), .data_we(data_we), .dir_we(dir_we),
    .pin_mask(pin_mask), .wdata(bus_wdata), .dir_q(dir_q), .data_q(data_q)
  );

  gpio_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(pad_in), .sync_out(pin_sync)
  );

  gpio_read_mux #(.NUM_PINS(NUM_PINS)) u_rdmux (
    .clk(clk), .rst(rst), .rd_en(rd_en), .kind(kind), .pin_mask(pin_mask),
    .dir_q(dir_q), .data_q(data_q), .pin_sync(pin_sync), .rdata_q(bus_rdata)
  );

  assign pad_out = data_q;
  assign pad_oe  = dir_q;

  // R1: reset leaves no pad driven
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (pad_oe == '0 && pad_out == '0 && bus_rdata == '0));
endmodule

// File: tb/tb_gpio_masked_port.sv
module tb_gpio_masked_port;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYCLES = 5000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pad_in = '0;
  logic [7:0] pad_out;
  logic [7:0] pad_oe;

  int n_checks = 0;
  int n_fail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_seen = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_masked_port dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard when read data is due.
  always @(posedge clk) rd_seen <= bus_sel && !bus_wr;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) check("scoreboard underflow", 8'hFF, 8'h00);
      else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  // Tasks start on a falling edge and return on the next one.
  task automatic wr(logic [11:0] a, logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
  endtask

  task automatic rd(logic [11:0] a, logic [7:0] e, string tag);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
  endtask

  task automatic idle();
    bus_sel = 1'b0; bus_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (WDOG_CYCLES) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 pad_oe after reset", pad_oe, 8'h00);
    check("R1 pad_out after reset", pad_out, 8'h00);
    check("R1 rdata after reset", bus_rdata, 8'h00);
    rd(12'h400, 8'h00, "R1 direction after reset");
    idle();

    // R2/R3: low nibble becomes output
    wr(12'h400, 8'h0F);
    idle();
    check("R2 pad_oe after dir write", pad_oe, 8'h0F);
    rd(12'h401, 8'h0F, "R3 direction read-back");
    idle();

    // R4/R5: full-mask write, only outputs accept
    wr(12'h3FC, 8'hFF);
    idle();
    check("R5 full-mask write hits outputs only", pad_out, 8'h0F);
    // R4: mask pins 0 and 2 (address bits 2 and 4)
    wr(12'h014, 8'h00);
    idle();
    check("R4 masked clear of pins 0,2", pad_out, 8'h0A);
    wr(12'h000, 8'h00);
    idle();
    check("R4 zero mask changes nothing", pad_out, 8'h0A);

    // R7/R8: pad opposite to driven values on low nibble
    pad_in = 8'hF5;
    repeat (3) idle();
    rd(12'h3FC, 8'hFA, "R7 R8 full read mixes driven and pad");
    rd(12'h0C0, 8'h30, "R6 mask pins 4,5");
    rd(12'h00C, 8'h02, "R6 mask pins 0,1");
    idle();

    // R8: synchronizer latency, pad change aligned with first strobe
    pad_in = 8'h05;
    rd(12'h3C0, 8'hF0, "R8 first edge old level");
    rd(12'h3C0, 8'hF0, "R8 second edge old level");
    rd(12'h3C0, 8'h00, "R8 third edge new level");
    idle();
    check("R9 rdata zero without strobe", bus_rdata, 8'h00);

    // R5: reveal stored values of former inputs
    wr(12'h400, 8'hFF);
    idle();
    check("R5 former inputs drive old value", pad_out, 8'h0A);
    wr(12'h3FC, 8'hC3);
    idle();
    check("R4 write after switch to output", pad_out, 8'hC3);
    pad_in = 8'h3C;
    repeat (3) idle();
    rd(12'h3FC, 8'hC3, "R7 read returns driven value");
    idle();

    // R10: out-of-window accesses
    wr(12'h400, 8'h3C);
    wr(12'h404, 8'hFF);
    wr(12'h800, 8'h00);
    idle();
    check("R10 hole write leaves pad_oe", pad_oe, 8'h3C);
    check("R10 hole write leaves pad_out", pad_out, 8'hC3);
    rd(12'h400, 8'h3C, "R10 R3 direction unchanged");
    rd(12'h404, 8'h00, "R10 read of 0x404");
    rd(12'hFFC, 8'h00, "R10 read of 0xFFC");
    idle();
    idle();
    check("R9 rdata zero after idle", bus_rdata, 8'h00);
    check("scoreboard drained", 8'(exp_q.size()), 8'h00);
    finish_run();
  end
endmodule